// File: doc/BRIEF.md
# In-Router Sharer Tree Cache

This block sits inside one mesh router and keeps a small table of sharer trees, one entry per cache line that the router currently helps to track. For each line it remembers which of its four links (north, east, south, west) leads toward the line's home node and which links lead away from it, toward sharers. It also remembers whether the node attached to its local port holds a valid copy. Coherence messages for a tracked line are steered by this stored tree instead of by plain routing. A read that runs into the tree is diverted toward a sharer. A read reply grows the tree hop by hop as it returns. An invalidation fans out along every child branch, and the router collects one acknowledgement per branch before it sends a single acknowledgement toward the root.

The router core hands the block one message per cycle: its type, line address, the port it arrived on, and the port that normal routing would pick for it. One cycle later the block reports the message it emits, with a five-bit port mask, or reports that the message must be held in its buffer. When the table is full and a new line has to be added, the least recently used entry that is not busy is evicted, and a teardown for it appears on a separate output in the same cycle.

Top module: `vtree_cache`

## Requirements
- R1: After reset the table is empty and out_valid, out_held and ev_valid are low. Every lookup therefore misses.
- R2: The result of a message accepted with in_valid appears exactly one cycle later. Type codes: read request 0, read reply 1, write request 2, invalidate 3, acknowledge 4, teardown 5. Port codes: north 0, east 1, south 2, west 3, local 4. Mask bit k stands for port k. A read request that misses is forwarded unchanged to the port given by in_next.
- R3: A read reply is always forwarded to in_next. For its line it records the arrival link as the root link, or no root link when it arrives on the local port. It also records in_next as a child link, or sets local-valid when in_next is the local port. A line with no entry gets a new one.
- R4: A read request that hits a non-busy entry with local-valid set is sent to the local port only.
- R5: A read request that hits a non-busy entry without local-valid is sent to the lowest-numbered child link other than its arrival link. When no such link exists, it goes to in_next.
- R6: A write request or invalidate that hits a non-busy entry emits an invalidate. Its mask holds every child link except the arrival link, plus the local port when local-valid is set. The entry becomes busy and expects one acknowledgement per port in that mask.
- R7: When that mask would be empty, an acknowledgement is emitted instead and the entry is removed. It goes on the root link, or to the local port when the entry has no root link.
- R8: An acknowledgement for a busy entry emits nothing until the last expected acknowledgement arrives. The last one sends an acknowledgement toward the root as in R7 and removes the entry. An acknowledgement with no busy entry is forwarded to in_next.
- R9: A read request, write request, invalidate or teardown that hits a busy entry raises out_held with out_valid low and leaves the entry unchanged. A read reply to a busy line is only forwarded.
- R10: An invalidate that misses is answered with an acknowledgement on its arrival port. A write request that misses is forwarded to in_next.
- R11: A teardown clears the arrival link (or local-valid, when it arrives on the local port). If no child link and no local-valid remain, the entry is removed and a teardown is sent on its root link, or nothing is sent when the entry has no root link. A teardown that misses emits nothing.
- R12: A read reply for an untracked line when the table is full evicts the least recently used non-busy entry. ev_valid then carries the victim's address and its root port as a teardown. When every entry is busy, the reply is only forwarded and no entry is created.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A message is presented this cycle |
| in_type | input | 3 | Message type code |
| in_addr | input | ADDR_W | Cache line address |
| in_dir | input | 3 | Port the message arrived on |
| in_next | input | 3 | Port chosen by normal routing |
| out_valid | output | 1 | A message is emitted |
| out_type | output | 3 | Type of the emitted message |
| out_addr | output | ADDR_W | Line address of the emitted message |
| out_mask | output | 5 | Ports the message leaves on |
| out_held | output | 1 | Input message must stay buffered (line busy) |
| ev_valid | output | 1 | Eviction teardown is emitted |
| ev_addr | output | ADDR_W | Address of the evicted line |
| ev_mask | output | 5 | Port toward the evicted line's root |

## Verification
The bench builds the block with ENTRIES = 4 and ADDR_W = 12. With four entries, the table fills after a handful of read replies. Full-table eviction, choosing a victim by recency, and the case where every entry is busy so nothing can be evicted all fall within a short directed sequence. The narrower address only keeps the expected values readable. The tree walk itself (redirects, fan-out counts, acknowledgement collection, root and leaf cases) does not depend on either parameter.

// File: rtl/vtc_pkg.sv
// Shared encodings and helpers for the in-router sharer tree cache.
// Assumes four mesh links (codes 0..3) plus one local port (code 4).
package vtc_pkg;

    typedef enum logic [2:0] {
        MSG_RD_REQ   = 3'd0,
        MSG_RD_REP   = 3'd1,
        MSG_WR_REQ   = 3'd2,
        MSG_INV      = 3'd3,
        MSG_ACK      = 3'd4,
        MSG_TEARDOWN = 3'd5
    } msg_e;

    localparam int NLINK = 4;
    localparam int NPORT = NLINK + 1;
    localparam logic [2:0] PORT_LOCAL = 3'd4;

    // One-hot link vector for a port code; local and unused codes give zero.
    function automatic logic [NLINK-1:0] link_bit(input logic [2:0] p);
        link_bit = (p < 3'd4) ? (4'b0001 << p[1:0]) : 4'b0000;
    endfunction

    // One-hot port vector for a port code; unused codes give zero.
    function automatic logic [NPORT-1:0] port_bit(input logic [2:0] p);
        port_bit = (p <= PORT_LOCAL) ? (5'b00001 << p) : 5'b00000;
    endfunction

    // Number of set links in a link vector.
    function automatic logic [2:0] count_links(input logic [NLINK-1:0] m);
        count_links = 3'(m[0]) + 3'(m[1]) + 3'(m[2]) + 3'(m[3]);
    endfunction

endpackage

// File: rtl/vtc_match.sv
// Fully associative tag match over the tree table.
// Assumes at most one valid entry per address; lowest index wins otherwise.
module vtc_match #(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 16
) (
    input  logic [ENTRIES-1:0]             ent_vld,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag,
    input  logic [ADDR_W-1:0]              key,
    output logic                           hit,
    output logic [$clog2(ENTRIES)-1:0]     hit_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] eq;

    // Per-entry comparators.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = ent_vld[g] && (ent_tag[g] == key);
    end

    // Reduce the match vector to a hit flag and an index.
    always_comb begin
        hit     = |eq;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/vtc_lru.sv
// Recency ranks for the tree table and victim choice.
// Ranks form a permutation (0 = most recent). A free slot is preferred;
// otherwise the oldest entry that is not busy is picked.
module vtc_lru #(
    parameter int ENTRIES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        touch,
    input  logic [$clog2(ENTRIES)-1:0]  touch_idx,
    input  logic [ENTRIES-1:0]          ent_vld,
    input  logic [ENTRIES-1:0]          ent_busy,
    output logic                        victim_ok,
    output logic [$clog2(ENTRIES)-1:0]  victim_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0][IDX_W-1:0] rank_q;
    logic                          free_found;
    logic                          old_found;
    logic [IDX_W-1:0]              best_rank;

    // Move the touched entry to rank 0 and age those that were newer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    rank_q[i] <= '0;
                else if (rank_q[i] < rank_q[touch_idx])
                    rank_q[i] <= rank_q[i] + 1'b1;
            end
        end
    end

    // Choose a free slot first, else the oldest non-busy entry.
    always_comb begin
        free_found = 1'b0;
        old_found  = 1'b0;
        best_rank  = '0;
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!ent_vld[i] && !free_found) begin
                free_found = 1'b1;
                victim_idx = IDX_W'(i);
            end
        end
        if (!free_found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (!ent_busy[i] && (!old_found || rank_q[i] > best_rank)) begin
                    old_found  = 1'b1;
                    best_rank  = rank_q[i];
                    victim_idx = IDX_W'(i);
                end
            end
        end
        victim_ok = free_found || old_found;
    end

endmodule

// File: rtl/vtree_cache.sv
// In-router sharer tree cache: stores per-line tree links and steers
// coherence messages along them. One message per cycle enters; the
// emitted message (or a hold indication) leaves one cycle later.
// Assumes the router core serialises messages and supplies, in in_next,
// the port that plain routing would choose.
module vtree_cache
    import vtc_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ADDR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_type,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [2:0]        in_dir,
    input  logic [2:0]        in_next,
    output logic              out_valid,
    output logic [2:0]        out_type,
    output logic [ADDR_W-1:0] out_addr,
    output logic [4:0]        out_mask,
    output logic              out_held,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [4:0]        ev_mask
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = 3;
    localparam logic [NPORT-1:0] LOCAL_MASK = NPORT'(1) << PORT_LOCAL;

    // Table state
    logic [ENTRIES-1:0]             vld_q, dloc_q, busy_q, outst_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][NLINK-1:0]  up_q, dn_q;
    logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q;

    // Lookup and victim
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic             victim_ok;
    logic [IDX_W-1:0] victim_idx;

    // Decision outputs
    logic              we, touch;
    logic [IDX_W-1:0]  widx;
    logic              n_vld, n_dloc, n_busy, n_outst;
    logic [ADDR_W-1:0] n_tag;
    logic [NLINK-1:0]  n_up, n_dn;
    logic [CNT_W-1:0]  n_cnt;
    logic              o_v, o_h, e_v;
    logic [2:0]        o_t;
    logic [NPORT-1:0]  o_m, e_m;
    logic [ADDR_W-1:0] e_a;

    // Decoded input and hit-entry view
    logic [NLINK-1:0] arr_link, nxt_link, h_up, h_dn, kids, low_kid, v_up;
    logic [NPORT-1:0] arr_port, nxt_port, up_port;
    logic             h_dloc, h_busy, h_outst, nxt_local;
    logic [CNT_W-1:0] h_cnt, fan_cnt;
    logic [NLINK-1:0] left_dn;
    logic             left_loc;

    vtc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .ent_vld (vld_q),
        .ent_tag (tag_q),
        .key     (in_addr),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    vtc_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (widx),
        .ent_vld    (vld_q),
        .ent_busy   (busy_q),
        .victim_ok  (victim_ok),
        .victim_idx (victim_idx)
    );

    // Decode ports and read out the hit entry.
    always_comb begin
        arr_link  = link_bit(in_dir);
        arr_port  = port_bit(in_dir);
        nxt_link  = link_bit(in_next);
        nxt_port  = port_bit(in_next);
        nxt_local = (in_next == PORT_LOCAL);
        h_up      = up_q[hit_idx];
        h_dn      = dn_q[hit_idx];
        h_dloc    = dloc_q[hit_idx];
        h_busy    = busy_q[hit_idx];
        h_outst   = outst_q[hit_idx];
        h_cnt     = cnt_q[hit_idx];
        kids      = h_dn & ~arr_link;
        low_kid   = kids & (~kids + 4'd1);
        fan_cnt   = count_links(kids) + CNT_W'(h_dloc);
        up_port   = (h_up != '0) ? {1'b0, h_up} : LOCAL_MASK;
        left_dn   = h_dn & ~arr_link;
        left_loc  = h_dloc && (in_dir != PORT_LOCAL);
        v_up      = up_q[victim_idx];
    end

    // Per-message steering and table update decision.
    always_comb begin
        we = 1'b0; touch = 1'b0; widx = hit_idx;
        n_vld = 1'b1; n_tag = tag_q[hit_idx]; n_up = h_up; n_dn = h_dn;
        n_dloc = h_dloc; n_busy = h_busy; n_outst = h_outst; n_cnt = h_cnt;
        o_v = 1'b0; o_h = 1'b0; o_t = in_type; o_m = '0;
        e_v = 1'b0; e_a = tag_q[victim_idx];
        e_m = (v_up != '0) ? {1'b0, v_up} : LOCAL_MASK;
        if (in_valid) begin
            case (in_type)
                MSG_RD_REQ: begin
                    if (hit && h_busy) begin
                        o_h = 1'b1;
                    end else if (hit) begin
                        o_v = 1'b1; we = 1'b1; touch = 1'b1; n_outst = 1'b1;
                        if (h_dloc)            o_m = LOCAL_MASK;
                        else if (kids != '0)   o_m = {1'b0, low_kid};
                        else                   o_m = nxt_port;
                    end else begin
                        o_v = 1'b1; o_m = nxt_port;
                    end
                end
                MSG_RD_REP: begin
                    o_v = 1'b1; o_m = nxt_port;
                    if (hit && !h_busy) begin
                        we = 1'b1; touch = 1'b1; n_outst = 1'b0;
                        if (arr_link != '0) n_up = arr_link;
                        n_dn   = h_dn | nxt_link;
                        n_dloc = h_dloc | nxt_local;
                    end else if (!hit && victim_ok) begin
                        we = 1'b1; touch = 1'b1; widx = victim_idx;
                        n_tag = in_addr; n_up = arr_link; n_dn = nxt_link;
                        n_dloc = nxt_local; n_busy = 1'b0; n_outst = 1'b0;
                        n_cnt = '0;
                        e_v = vld_q[victim_idx];
                    end
                end
                MSG_WR_REQ, MSG_INV: begin
                    if (hit && h_busy) begin
                        o_h = 1'b1;
                    end else if (hit && fan_cnt == '0) begin
                        o_v = 1'b1; o_t = MSG_ACK; o_m = up_port;
                        we = 1'b1; n_vld = 1'b0; n_busy = 1'b0;
                    end else if (hit) begin
                        o_v = 1'b1; o_t = MSG_INV;
                        o_m = {h_dloc, kids};
                        we = 1'b1; touch = 1'b1; n_busy = 1'b1; n_cnt = fan_cnt;
                    end else if (in_type == MSG_INV) begin
                        o_v = 1'b1; o_t = MSG_ACK; o_m = arr_port;
                    end else begin
                        o_v = 1'b1; o_m = nxt_port;
                    end
                end
                MSG_ACK: begin
                    if (hit && h_busy) begin
                        we = 1'b1;
                        if (h_cnt == CNT_W'(1)) begin
                            o_v = 1'b1; o_m = up_port;
                            n_vld = 1'b0; n_busy = 1'b0; n_cnt = '0;
                        end else begin
                            n_cnt = h_cnt - 1'b1;
                        end
                    end else begin
                        o_v = 1'b1; o_m = nxt_port;
                    end
                end
                MSG_TEARDOWN: begin
                    if (hit && h_busy) begin
                        o_h = 1'b1;
                    end else if (hit) begin
                        we = 1'b1; n_dn = left_dn; n_dloc = left_loc;
                        if (left_dn == '0 && !left_loc) begin
                            n_vld = 1'b0;
                            o_v   = (h_up != '0);
                            o_m   = {1'b0, h_up};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Write the chosen entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0; dloc_q <= '0; busy_q <= '0; outst_q <= '0;
            tag_q <= '0; up_q <= '0; dn_q <= '0; cnt_q <= '0;
        end else if (we) begin
            vld_q[widx]   <= n_vld;
            tag_q[widx]   <= n_tag;
            up_q[widx]    <= n_up;
            dn_q[widx]    <= n_dn;
            dloc_q[widx]  <= n_dloc;
            busy_q[widx]  <= n_busy;
            outst_q[widx] <= n_outst;
            cnt_q[widx]   <= n_cnt;
        end
    end

    // Register the emitted message, hold flag and eviction teardown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_type <= '0; out_addr <= '0; out_mask <= '0;
            out_held  <= 1'b0; ev_valid <= 1'b0; ev_addr <= '0; ev_mask <= '0;
        end else begin
            out_valid <= o_v;
            out_type  <= o_t;
            out_addr  <= in_addr;
            out_mask  <= o_m;
            out_held  <= o_h;
            ev_valid  <= e_v;
            ev_addr   <= e_a;
            ev_mask   <= e_m;
        end
    end

endmodule

// File: rtl/vtc_checker.sv
// Port-level properties of the sharer tree cache, bound to every instance.
module vtc_checker
    import vtc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_type,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_valid,
    input logic [2:0]        out_type,
    input logic [ADDR_W-1:0] out_addr,
    input logic [4:0]        out_mask,
    input logic              out_held,
    input logic              ev_valid
);

    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid) && out_addr == $past(in_addr));

    p_mask_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_mask != 5'b0);

    p_read_single_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == MSG_RD_REQ) |-> $onehot(out_mask));

    p_ack_single_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type == MSG_ACK) |-> $onehot(out_mask));

    p_held_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_held |-> !out_valid && !ev_valid);

    p_held_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_held |-> $past(in_valid) && $past(in_type) != MSG_RD_REP
                     && $past(in_type) != MSG_ACK);

    p_evict_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> $past(in_valid) && $past(in_type) == MSG_RD_REP
                     && out_valid && out_type == MSG_RD_REP);

endmodule

bind vtree_cache vtc_checker #(.ADDR_W(ADDR_W)) u_vtc_checker (.*);

// File: tb/vtree_cache_bench.sv
// Scoreboard bench: the driver queues the expected result of each message,
// the monitor compares it one cycle later at the falling edge.
module vtree_cache_bench;
    localparam int ENTRIES = 4;
    localparam int AW      = 12;
    localparam logic [2:0] RQ = 3'd0, RP = 3'd1, WR = 3'd2, IV = 3'd3,
                           AK = 3'd4, TD = 3'd5;
    localparam logic [2:0] PN = 3'd0, PE = 3'd1, PS = 3'd2, PW = 3'd3, PL = 3'd4;
    localparam logic [4:0] MN = 5'b00001, ME = 5'b00010, MS = 5'b00100,
                           MW = 5'b01000, ML = 5'b10000;

    typedef struct packed {
        logic          v;
        logic [2:0]    t;
        logic [AW-1:0] a;
        logic [4:0]    m;
        logic          h;
        logic          ev;
        logic [AW-1:0] ea;
        logic [4:0]    em;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_type = '0;
    logic [AW-1:0] in_addr = '0;
    logic [2:0]    in_dir = '0;
    logic [2:0]    in_next = '0;
    logic          out_valid, out_held, ev_valid;
    logic [2:0]    out_type;
    logic [AW-1:0] out_addr, ev_addr;
    logic [4:0]    out_mask, ev_mask;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t expq[$];
    string tagq[$];

    always #10 clk = ~clk;

    vtree_cache #(.ENTRIES(ENTRIES), .ADDR_W(AW)) u_vtree_cache (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_type(in_type),
        .in_addr(in_addr), .in_dir(in_dir), .in_next(in_next),
        .out_valid(out_valid), .out_type(out_type), .out_addr(out_addr),
        .out_mask(out_mask), .out_held(out_held), .ev_valid(ev_valid),
        .ev_addr(ev_addr), .ev_mask(ev_mask)
    );

    function automatic exp_t emit(input logic [2:0] t, input logic [AW-1:0] a,
                                  input logic [4:0] m);
        emit = '{v:1'b1, t:t, a:a, m:m, h:1'b0, ev:1'b0, ea:'0, em:'0};
    endfunction

    function automatic exp_t quiet(input logic held);
        quiet = '{v:1'b0, t:'0, a:'0, m:'0, h:held, ev:1'b0, ea:'0, em:'0};
    endfunction

    // Drive one message and queue its expected result.
    task automatic send(input logic [2:0] t, input logic [AW-1:0] a,
                        input logic [2:0] d, input logic [2:0] nx,
                        input exp_t e, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_type = t; in_addr = a; in_dir = d; in_next = nx;
        @(posedge clk);
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        expq.push_back(quiet(1'b0));
        tagq.push_back(tag);
    endtask

    // Monitor: compare the design's registered result against the queue.
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t  e;
            string tg;
            bit    bad;
            e  = expq.pop_front();
            tg = tagq.pop_front();
            bad = (out_valid != e.v) || (out_held != e.h) || (ev_valid != e.ev);
            if (e.v && (out_type != e.t || out_addr != e.a || out_mask != e.m)) bad = 1'b1;
            if (e.ev && (ev_addr != e.ea || ev_mask != e.em)) bad = 1'b1;
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: got v=%0b t=%0d a=%h m=%b h=%0b ev=%0b ea=%h em=%b exp v=%0b t=%0d a=%h m=%b h=%0b ev=%0b ea=%h em=%b",
                         tg, out_valid, out_type, out_addr, out_mask, out_held, ev_valid, ev_addr, ev_mask,
                         e.v, e.t, e.a, e.m, e.h, e.ev, e.ea, e.em);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        exp_t x;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid || out_held || ev_valid) begin
            errors++;
            $display("FAIL R1: got v=%0b h=%0b ev=%0b expected all 0", out_valid, out_held, ev_valid);
        end
        rst_n = 1'b1;

        send(RQ, 12'h010, PL, PN, emit(RQ, 12'h010, MN), "R1 R2 miss forward");
        send(RP, 12'h010, PN, PL, emit(RP, 12'h010, ML), "R3 reply alloc");
        send(RQ, 12'h010, PE, PN, emit(RQ, 12'h010, ML), "R4 local sharer");
        send(RP, 12'h010, PL, PE, emit(RP, 12'h010, ME), "R3 reply extend");
        send(RP, 12'h020, PN, PW, emit(RP, 12'h020, MW), "R3 second line");
        send(RQ, 12'h020, PE, PN, emit(RQ, 12'h020, MW), "R5 child redirect");
        send(RQ, 12'h020, PW, PN, emit(RQ, 12'h020, MN), "R5 no other child");
        send(IV, 12'h010, PN, PN, emit(IV, 12'h010, 5'b10010), "R6 fan out");
        send(RQ, 12'h010, PS, PN, quiet(1'b1), "R9 read held");
        send(AK, 12'h010, PL, PN, quiet(1'b0), "R8 first ack absorbed");
        send(AK, 12'h010, PE, PN, emit(AK, 12'h010, MN), "R8 last ack up");
        send(RQ, 12'h010, PS, PW, emit(RQ, 12'h010, MW), "R8 entry removed");
        send(IV, 12'h030, PS, PN, emit(AK, 12'h030, MS), "R10 inv miss");
        send(WR, 12'h030, PL, PE, emit(WR, 12'h030, ME), "R10 write miss");
        send(TD, 12'h020, PW, PN, emit(TD, 12'h020, MN), "R11 teardown up");
        send(TD, 12'h020, PW, PN, quiet(1'b0), "R11 teardown miss");
        send(RQ, 12'h020, PE, PS, emit(RQ, 12'h020, MS), "R11 entry gone");
        send(RP, 12'h040, PW, PN, emit(RP, 12'h040, MN), "R7 setup leaf");
        send(IV, 12'h040, PN, PN, emit(AK, 12'h040, MW), "R7 leaf ack");
        send(RP, 12'h050, PL, PS, emit(RP, 12'h050, MS), "R7 setup root");
        send(IV, 12'h050, PS, PN, emit(AK, 12'h050, ML), "R7 root ack local");
        idle("R2 idle");

        send(RP, 12'h100, PN, PL, emit(RP, 12'h100, ML), "R12 fill 0");
        send(RP, 12'h101, PE, PL, emit(RP, 12'h101, ML), "R12 fill 1");
        send(RP, 12'h102, PS, PL, emit(RP, 12'h102, ML), "R12 fill 2");
        send(RP, 12'h103, PW, PL, emit(RP, 12'h103, ML), "R12 fill 3");
        send(RQ, 12'h100, PE, PN, emit(RQ, 12'h100, ML), "R4 touch");
        x = emit(RP, 12'h104, ML); x.ev = 1'b1; x.ea = 12'h101; x.em = ME;
        send(RP, 12'h104, PN, PL, x, "R12 evict oldest");
        send(RQ, 12'h101, PS, PW, emit(RQ, 12'h101, MW), "R12 victim gone");
        send(RQ, 12'h100, PS, PN, emit(RQ, 12'h100, ML), "R12 recent kept");
        send(IV, 12'h100, PN, PN, emit(IV, 12'h100, ML), "R6 busy 0");
        send(IV, 12'h102, PS, PN, emit(IV, 12'h102, ML), "R6 busy 2");
        send(IV, 12'h103, PW, PN, emit(IV, 12'h103, ML), "R6 busy 3");
        send(IV, 12'h104, PN, PN, emit(IV, 12'h104, ML), "R6 busy 4");
        send(RP, 12'h105, PN, PL, emit(RP, 12'h105, ML), "R12 all busy");
        send(RQ, 12'h105, PE, PS, emit(RQ, 12'h105, MS), "R12 not added");
        send(TD, 12'h100, PL, PN, quiet(1'b1), "R9 teardown held");
        send(RP, 12'h102, PS, PL, emit(RP, 12'h102, ML), "R9 reply to busy");
        send(AK, 12'h100, PL, PN, emit(AK, 12'h100, MN), "R8 single ack");
        send(AK, 12'h077, PE, PW, emit(AK, 12'h077, MW), "R8 ack forward");
        idle("R2 final idle");
        @(negedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule